// File: doc/BRIEF.md
# Dual Chip-Select SDRAM Address Decoder

This block maps a 32-bit interconnect address onto one of two external SDRAM chip-select regions inside a 1 GB controller window. The window starts at 0x8000_0000 and consists of eight 128 MB partitions. Region 0 always begins at the start of the window. Region 1 begins at a programmable partition boundary. Each region has a size counted in 2 MB units. A request is answered one clock later with an active-low one-hot chip-select, the offset of the address within the selected region, and a miss flag.

Three configuration words are reachable through a simple word-addressed register port: one memory-config word per region and one layout word that holds the region 1 start. The memory-config words take their reset contents from external strap inputs, and this includes their lock bits. A set lock bit freezes its word until the next reset. Command sequencing, timing parameters and the data path are handled elsewhere.

Top module: `sdram_cs_decoder`

## Requirements
- R1: While rst_n is low, config word 0 and config word 1 load strap_cfg0 and strap_cfg1, including bit 30. The layout word clears to zero. The decode outputs go idle: dec_valid=0, cs_n=2'b11, dec_miss=0, dec_offset=0.
- R2: reg_rdata is combinational from reg_addr and needs no read strobe. Word 0 is config 0 and word 1 is config 1; both store and return all 32 bits. Word 2 is the layout word: only bits [9:8] and [3:0] are kept, and every other bit reads 0. Word 3 reads 0 and ignores writes. A write happens on a clock edge when reg_we=1.
- R3: If bit 30 of a config word is 1, any write to that word is ignored and the word reads back unchanged.
- R4: An address is inside the window when req_addr[31:30]=2'b10. Let off=req_addr[29:0]. Region 0 hits when off < size0×2 MB, where size0 is config 0 bits [17:8]. A hit gives cs_n=2'b10 and dec_offset=off.
- R5: The region 1 partition is P={layout[3:0], layout[9:8]}. Region 1 hits when P×128 MB ≤ off < P×128 MB + size1×2 MB, where size1 is config 1 bits [17:8]. A hit gives cs_n=2'b01 and dec_offset=off−P×128 MB.
- R6: When both regions contain an address, region 0 is selected.
- R7: A valid request that is outside the window, or inside the window but in neither region, gives dec_miss=1, cs_n=2'b11 and dec_offset=0.
- R8: A region that would extend past the end of the window is cut off at the window end. Addresses at or above 0xC000_0000 never hit. If P≥8, region 1 never hits.
- R9: The outputs are registered. dec_valid equals req_valid from the previous edge, so back-to-back requests are each answered on the following cycle. When the previous req_valid was 0, the outputs are idle as in R1.
- R10: The deep-power-down flag, config bit 3, has no effect on the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_cfg0 | input | 32 | Reset contents of config word 0 |
| strap_cfg1 | input | 32 | Reset contents of config word 1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| req_valid | input | 1 | Decode request valid |
| req_addr | input | 32 | Interconnect address to decode |
| dec_valid | output | 1 | Decode result valid |
| cs_n | output | 2 | Active-low one-hot chip-select |
| dec_offset | output | 30 | Offset within the selected region |
| dec_miss | output | 1 | Address hits no region |

## Verification
A corrupted or wrongly written config or layout word shows up at once on reg_rdata. It also shows up one cycle after the next request, as a region boundary in the wrong place. Broken locking shows as a changed readback straight after the blocked write. Broken priority or clipping shows as the wrong chip-select, or as a miss, on a request placed just inside or just outside a boundary. Wrong region 1 offset arithmetic shows as a wrong dec_offset at the first address of that region.

// File: rtl/sdram_cs_decoder.sv
module sdram_cs_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] strap_cfg0,
  input  logic [31:0] strap_cfg1,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        dec_valid,
  output logic [1:0]  cs_n,
  output logic [29:0] dec_offset,
  output logic        dec_miss
);
  localparam int LOCK_BIT = 30;
  localparam int UNIT_LSB = 21;
  localparam int PART_LSB = 27;

  logic [31:0] cfg0_q, cfg1_q;
  logic [5:0]  part_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= strap_cfg0;
      cfg1_q <= strap_cfg1;
      part_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: if (!cfg0_q[LOCK_BIT]) cfg0_q <= reg_wdata;
        2'd1: if (!cfg1_q[LOCK_BIT]) cfg1_q <= reg_wdata;
        2'd2: part_q <= {reg_wdata[3:0], reg_wdata[9:8]};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = cfg0_q;
      2'd1:    reg_rdata = cfg1_q;
      2'd2:    reg_rdata = {22'b0, part_q[1:0], 4'b0, part_q[5:2]};
      default: reg_rdata = '0;
    endcase
  end

  logic        in_win, hit0, hit1;
  logic [29:0] off;
  logic [12:0] unit, r1_lo, r1_hi;

  assign in_win = (req_addr[31:30] == 2'b10);
  assign off    = req_addr[29:0];
  assign unit   = {4'b0, off[29:UNIT_LSB]};
  assign r1_lo  = {1'b0, part_q, 6'b0};
  assign r1_hi  = r1_lo + {3'b0, cfg1_q[17:8]};
  assign hit0   = in_win && (unit < {3'b0, cfg0_q[17:8]});
  assign hit1   = in_win && (unit >= r1_lo) && (unit < r1_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      cs_n       <= 2'b11;
      dec_offset <= '0;
      dec_miss   <= 1'b0;
    end else begin
      dec_valid  <= req_valid;
      cs_n       <= 2'b11;
      dec_offset <= '0;
      dec_miss   <= 1'b0;
      if (req_valid) begin
        if (hit0) begin
          cs_n       <= 2'b10;
          dec_offset <= off;
        end else if (hit1) begin
          cs_n       <= 2'b01;
          dec_offset <= off - {part_q[2:0], {PART_LSB{1'b0}}};
        end else begin
          dec_miss   <= 1'b1;
        end
      end
    end
  end
endmodule

module sdram_cs_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        dec_valid,
  input logic [1:0]  cs_n,
  input logic        dec_miss,
  input logic [31:0] cfg0_q,
  input logic [31:0] cfg1_q
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!dec_valid && cs_n == 2'b11 && !dec_miss));
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r7_miss_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> cs_n == 2'b11);
  a_r7_valid_answers: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_miss != (cs_n != 2'b11)));
  a_r8_outside_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:30] != 2'b10) |=> dec_miss);
  a_r3_lock0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg0_q[30] |=> $stable(cfg0_q));
  a_r3_lock1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg1_q[30] |=> $stable(cfg1_q));
endmodule

bind sdram_cs_decoder sdram_cs_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .dec_valid(dec_valid), .cs_n(cs_n), .dec_miss(dec_miss),
  .cfg0_q(cfg0_q), .cfg1_q(cfg1_q)
);

// File: tb/sdram_cs_decoder_tb.sv
module sdram_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] strap_cfg0 = 32'h0000_4000;
  logic [31:0] strap_cfg1 = 32'h4000_2000;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        dec_valid;
  logic [1:0]  cs_n;
  logic [29:0] dec_offset;
  logic        dec_miss;

  int errors = 0;
  int checks = 0;
  int s0 = 64, s1 = 32, p = 0;

  sdram_cs_decoder dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic model(logic [31:0] a, output logic [1:0] ecs,
                       output logic emiss, output logic [29:0] eoff);
    int unit;
    logic inw, h0, h1;
    inw  = (a[31:30] == 2'b10);
    unit = int'(a[29:21]);
    h0   = inw && (unit < s0);
    h1   = inw && (p < 8) && (unit >= p * 64) && (unit < p * 64 + s1);
    ecs = 2'b11; emiss = 1'b0; eoff = '0;
    if (h0) begin ecs = 2'b10; eoff = a[29:0]; end
    else if (h1) begin ecs = 2'b01; eoff = a[29:0] - 30'(p * 32'h0800_0000); end
    else emiss = 1'b1;
  endtask

  task automatic expect_dec(string req, logic [31:0] a);
    logic [1:0] ecs; logic emiss; logic [29:0] eoff;
    model(a, ecs, emiss, eoff);
    chk({req, " valid"}, dec_valid, 1'b1);
    chk({req, " cs_n"}, cs_n, ecs);
    chk({req, " miss"}, dec_miss, emiss);
    chk({req, " offset"}, dec_offset, eoff);
  endtask

  task automatic dec(string req, logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    expect_dec(req, a);
  endtask

  task automatic expect_idle(string req);
    chk({req, " idle valid"}, dec_valid, 1'b0);
    chk({req, " idle cs_n"}, cs_n, 2'b11);
    chk({req, " idle miss"}, dec_miss, 1'b0);
    chk({req, " idle offset"}, dec_offset, 30'h0);
  endtask

  task automatic t_reset;
    rd_chk("R1 cfg0 strap", 2'd0, 32'h0000_4000);
    rd_chk("R1 cfg1 strap", 2'd1, 32'h4000_2000);
    rd_chk("R1 layout zero", 2'd2, 32'h0);
    rd_chk("R2 word3 zero", 2'd3, 32'h0);
    expect_idle("R1");
  endtask

  task automatic t_regs;
    wr(2'd0, 32'h0000_8008); s0 = 128;
    rd_chk("R2 cfg0 readback", 2'd0, 32'h0000_8008);
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R2 layout mask", 2'd2, 32'h0000_030F);
    wr(2'd3, 32'h1234_5678);
    rd_chk("R2 word3 ignored", 2'd3, 32'h0);
    wr(2'd2, 32'h0000_0200); p = 2;
    rd_chk("R2 layout P=2", 2'd2, 32'h0000_0200);
  endtask

  task automatic t_lock1;
    wr(2'd1, 32'h0000_1000);
    rd_chk("R3 cfg1 locked", 2'd1, 32'h4000_2000);
  endtask

  task automatic t_region0;
    dec("R4 base", 32'h8000_0000);
    dec("R4 last word", 32'h8FFF_FFFC);
  endtask

  task automatic t_region1;
    dec("R5 first", 32'h9000_0000);
    dec("R5 last", 32'h93FF_FFFF);
    dec("R7 after region1", 32'h9400_0000);
  endtask

  task automatic t_miss;
    dec("R7 below window", 32'h7FFF_FFFF);
    dec("R7 above window", 32'hC000_0000);
    dec("R7 zero", 32'h0000_0000);
    dec("R7 gap", 32'hA000_0000);
  endtask

  task automatic t_overlap;
    wr(2'd2, 32'h0000_0100); p = 1;
    dec("R6 overlap start", 32'h8800_0000);
    dec("R6 overlap end", 32'h8BFF_FFFF);
  endtask

  task automatic t_pdflag;
    wr(2'd0, 32'h0000_8000);
    dec("R10 flag clear", 32'h8FFF_FFFC);
    dec("R10 flag clear edge", 32'h9000_0000);
    wr(2'd0, 32'h0000_8008);
    dec("R10 flag set", 32'h8FFF_FFFC);
  endtask

  task automatic t_clip;
    wr(2'd0, 32'h0003_FF00); s0 = 1023;
    dec("R8 clip top", 32'hBFFF_FFFF);
    dec("R8 past window", 32'hC000_0000);
    wr(2'd0, 32'h0000_0100); s0 = 1;
    wr(2'd2, 32'h0000_0301); p = 7;
    dec("R5 P=7 first", 32'hB800_0000);
    dec("R5 P=7 last", 32'hBBFF_FFFF);
    wr(2'd2, 32'h0000_0302); p = 11;
    dec("R8 P>=8 none", 32'hB800_0000);
    dec("R4 small region", 32'h8010_0000);
  endtask

  task automatic t_timing;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h8010_0000;
    @(negedge clk);
    expect_dec("R9 b2b first", 32'h8010_0000);
    req_addr = 32'h9000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    expect_dec("R9 b2b second", 32'h9000_0000);
    req_addr = 32'h8000_0000;
    @(negedge clk);
    expect_idle("R9");
  endtask

  task automatic t_lock0;
    wr(2'd0, 32'h4000_0200); s0 = 2;
    rd_chk("R3 cfg0 lock set", 2'd0, 32'h4000_0200);
    wr(2'd0, 32'h0000_FF00);
    rd_chk("R3 cfg0 write blocked", 2'd0, 32'h4000_0200);
    dec("R3 size unchanged", 32'h8060_0000);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_regs();
    t_lock1();
    t_region0();
    t_region1();
    t_miss();
    t_overlap();
    t_pdflag();
    t_clip();
    t_timing();
    t_lock0();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule